// File: doc/BRIEF.md
# Flash Mailbox Command Register Front-End

This block is a word-addressed register slave that lets a host compose single serial-flash commands and hand them to a mailbox transport. Software can build a raw command. It writes an opcode word with read and write flags, a byte count and up to eight bytes of payload, then sets an execute bit. Software can also use one of the fixed-function registers instead: open or close exclusive access, write enable, write or read the flash status byte, sector erase, or device-ID read. Each launch produces exactly one command packet on a valid/ready request port.

The transport answers on a response port with an 11-bit status code and up to 64 bits of read data. The front-end stores the code and any read data, and raises a registered interrupt from two latched event bits, each gated by an enable bit. The error bit can only be cleared by reset.

Request port back-pressure rules:
- The transport may hold `req_ready` low for any number of cycles.
- While `req_valid` is high and `req_ready` is low, every packet field stays frozen.
- The response port is ready only while a dispatched command is awaiting its answer.
- A `rsp_valid` pulse outside that window is ignored.

Top module: `fmb_cmd_frontend`

## Requirements
- R1: After reset:
  - the enable register (offset 2) reads 3;
  - every other offset reads 0;
  - `irq` is 0 and `req_valid` is 0.
- R2: Writing offset 13 with bit 0 set and bit 5 clear emits one packet with `req_kind`=0, the following fields, and `req_cs` equal to offset 3.
  - `req_opcode` is taken from bits 31:24 of the written word.
  - `req_rd` is taken from bit 6 and `req_wr` from bit 5.
  - `req_data` is {offset 16, offset 15}.
- R3: A raw launch written with bit 5 set does not dispatch. It waits, with register writes still accepted, until the next write to offset 15, then dispatches using the register contents as they stand at that point.
- R4: A byte count (offset 14, bits 3:0) above 8 is sent as 8. Counts of 0 to 8 are sent unchanged.
- R5: Fixed functions send packets with `req_opcode`=0 and no payload unless stated otherwise.
  - Writing 1 in bit 0 to offset 4, 5 or 6 sends kind 1 (open), 2 (close) or 3 (write enable), with 0 bytes. Writing 0 there sends nothing.
  - Any write to offset 7 sends kind 4 with `req_wr`=1, 1 byte, and `req_data[7:0]` equal to bits 7:0 of the written word.
  - Any write to offset 8 sends kind 5 with `req_rd`=1 and 1 byte.
  - Any write to offset 10 sends kind 7 with `req_rd`=1 and 4 bytes.
- R6: Any write to offset 9 sends kind 6 with `req_wr`=1 and 4 bytes. The address goes most significant byte first: `req_data[7:0]` is address bits 31:24, and so on down to `req_data[31:24]`, which is address bits 7:0. The upper 32 data bits are 0.
- R7: While `req_valid`=1 and `req_ready`=0, the packet stays unchanged. After the handshake, `req_valid` drops and no second packet follows.
- R8: `rsp_ready` is 1 only between request handshake and response.
  - The accepted status code reads back at offset 0, bits 10:0.
  - Offset 0 bit 11 reads 1 from launch dispatch until the response.
- R9: Any register write while offset 0 bit 11 is 1 is ignored.
- R10: A response with a non-zero status sets offset 1 bit 0. That bit stays set until reset, and writes do not clear it.
- R11: A zero-status response to a read command:
  - sets offset 1 bit 1;
  - for a raw command, loads offsets 17 (low 32 bits) and 18 (high 32 bits);
  - for kind 5, loads offset 8 from data bits 7:0;
  - for kind 7, loads offset 10 from data bits 31:0.
  Writing 1 to offset 1 bit 1 clears it.
- R12: `irq` equals, one cycle later, the OR of (offset 1 bit n AND offset 2 bit n) for n = 0 and 1.
- R13: Offsets 11, 12 and 19 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| req_valid | output | 1 | Command packet valid |
| req_ready | input | 1 | Transport accepts packet |
| req_kind | output | 3 | Command kind (0 raw, 1 open, 2 close, 3 write enable, 4 write status, 5 read status, 6 erase, 7 read ID) |
| req_opcode | output | 8 | Raw opcode |
| req_rd | output | 1 | Command returns data |
| req_wr | output | 1 | Command carries data |
| req_nbytes | output | 4 | Data byte count, at most 8 |
| req_data | output | 64 | Payload, byte 0 in bits 7:0 sent first |
| req_cs | output | 4 | Device select |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Front-end awaits a response |
| rsp_status | input | 11 | Response code, 0 means success |
| rsp_data | input | 64 | Read data |
| irq | output | 1 | Registered interrupt |

## Verification
The bench sweeps every byte-count value from 0 to 15 with varying back-pressure.
- A wrong clamp would send counts of 9 or more.
- A packet that slips under back-pressure would change fields mid-transfer.

The deferred raw launch is tested with its data written last. A design that launches early would send stale data, and one that blocks writes while armed would send the old count.

Several things are checked through register read-back after the response:
- writes made during the busy window, which a leaky write gate would let through;
- a stray second execute, which would appear as an extra packet;
- erase byte order, which a design that forgets the swap would send unreversed;
- the sticky error bit against clear attempts.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 32;
  localparam int STAT_W = 11;
  localparam int CS_W   = 4;
  localparam int CNT_W  = 4;
  localparam int PAY_W  = 64;
  localparam int OPC_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'd0;
  localparam logic [ADDR_W-1:0] OFS_ISR    = 5'd1;
  localparam logic [ADDR_W-1:0] OFS_IER    = 5'd2;
  localparam logic [ADDR_W-1:0] OFS_CSEL   = 5'd3;
  localparam logic [ADDR_W-1:0] OFS_OPEN   = 5'd4;
  localparam logic [ADDR_W-1:0] OFS_CLOSE  = 5'd5;
  localparam logic [ADDR_W-1:0] OFS_WREN   = 5'd6;
  localparam logic [ADDR_W-1:0] OFS_WRSTAT = 5'd7;
  localparam logic [ADDR_W-1:0] OFS_RDSTAT = 5'd8;
  localparam logic [ADDR_W-1:0] OFS_ERASE  = 5'd9;
  localparam logic [ADDR_W-1:0] OFS_DEVID  = 5'd10;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'd13;
  localparam logic [ADDR_W-1:0] OFS_NB     = 5'd14;
  localparam logic [ADDR_W-1:0] OFS_WD0    = 5'd15;
  localparam logic [ADDR_W-1:0] OFS_WD1    = 5'd16;
  localparam logic [ADDR_W-1:0] OFS_RD0    = 5'd17;
  localparam logic [ADDR_W-1:0] OFS_RD1    = 5'd18;

  typedef enum logic [2:0] {
    K_RAW    = 3'd0,
    K_OPEN   = 3'd1,
    K_CLOSE  = 3'd2,
    K_WREN   = 3'd3,
    K_WRSTAT = 3'd4,
    K_RDSTAT = 3'd5,
    K_ERASE  = 3'd6,
    K_DEVID  = 3'd7
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2,
    ST_WAIT  = 2'd3
  } launch_state_e;

  typedef struct packed {
    cmd_kind_e          kind;
    logic [OPC_W-1:0]   opcode;
    logic               rd;
    logic               wr;
    logic [CNT_W-1:0]   nbytes;
    logic [PAY_W-1:0]   data;
    logic [CS_W-1:0]    cs;
  } cmd_pkt_t;
endpackage

// File: rtl/fmb_packer.sv
module fmb_packer
  import fmb_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  cmd_kind_e          kind,
  input  logic [OPC_W-1:0]   ctrl_opcode,
  input  logic               ctrl_rd,
  input  logic               ctrl_wr,
  input  logic [CNT_W-1:0]   nbytes_reg,
  input  logic [WORD_W-1:0]  wdata0,
  input  logic [WORD_W-1:0]  wdata1,
  input  logic [7:0]         wrstat_reg,
  input  logic [WORD_W-1:0]  erase_addr,
  input  logic [CS_W-1:0]    csel,
  output cmd_pkt_t           pkt
);
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam logic [CNT_W-1:0] CLAMP = CNT_W'(MAX_BYTES);

  logic [WORD_W-1:0] addr_swapped;

  always_comb begin
    for (int b = 0; b < BYTES_PER_WORD; b++) begin
      addr_swapped[b*8 +: 8] = erase_addr[(BYTES_PER_WORD-1-b)*8 +: 8];
    end
  end

  always_comb begin
    pkt        = '0;
    pkt.kind   = kind;
    pkt.cs     = csel;
    unique case (kind)
      K_RAW: begin
        pkt.opcode = ctrl_opcode;
        pkt.rd     = ctrl_rd;
        pkt.wr     = ctrl_wr;
        pkt.nbytes = (nbytes_reg > CLAMP) ? CLAMP : nbytes_reg;
        pkt.data   = {wdata1, wdata0};
      end
      K_WRSTAT: begin
        pkt.wr        = 1'b1;
        pkt.nbytes    = CNT_W'(1);
        pkt.data[7:0] = wrstat_reg;
      end
      K_RDSTAT: begin
        pkt.rd     = 1'b1;
        pkt.nbytes = CNT_W'(1);
      end
      K_ERASE: begin
        pkt.wr               = 1'b1;
        pkt.nbytes           = CNT_W'(BYTES_PER_WORD);
        pkt.data[WORD_W-1:0] = addr_swapped;
      end
      K_DEVID: begin
        pkt.rd     = 1'b1;
        pkt.nbytes = CNT_W'(BYTES_PER_WORD);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fmb_launcher.sv
module fmb_launcher
  import fmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_req,
  input  cmd_kind_e  launch_kind,
  input  logic       launch_hold,
  input  logic       wd0_wr,
  input  logic       req_ready,
  input  logic       rsp_valid,
  output cmd_kind_e  kind_q,
  output logic       req_valid,
  output logic       rsp_ready,
  output logic       busy,
  output logic       rsp_fire
);
  launch_state_e state_q, state_d;
  cmd_kind_e     kind_d;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    unique case (state_q)
      ST_IDLE, ST_ARMED: begin
        if (launch_req) begin
          kind_d  = launch_kind;
          state_d = launch_hold ? ST_ARMED : ST_SEND;
        end else if (state_q == ST_ARMED && wd0_wr) begin
          state_d = ST_SEND;
        end
      end
      ST_SEND: if (req_ready) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_RAW;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
    end
  end

  assign req_valid = (state_q == ST_SEND);
  assign rsp_ready = (state_q == ST_WAIT);
  assign busy      = (state_q == ST_SEND) || (state_q == ST_WAIT);
  assign rsp_fire  = rsp_ready && rsp_valid;
endmodule

// File: rtl/fmb_regfile.sv
module fmb_regfile
  import fmb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic               busy,
  input  logic               rsp_fire,
  input  logic [STAT_W-1:0]  rsp_status,
  input  logic [PAY_W-1:0]   rsp_data,
  input  cmd_kind_e          cur_kind,
  input  logic               cur_rd,
  output logic               launch_req,
  output cmd_kind_e          launch_kind,
  output logic               launch_hold,
  output logic               wd0_wr,
  output logic [OPC_W-1:0]   ctrl_opcode,
  output logic               ctrl_rd,
  output logic               ctrl_wr,
  output logic [CNT_W-1:0]   nbytes_reg,
  output logic [WORD_W-1:0]  wdata0,
  output logic [WORD_W-1:0]  wdata1,
  output logic [7:0]         wrstat_reg,
  output logic [WORD_W-1:0]  erase_addr,
  output logic [CS_W-1:0]    csel,
  output logic [1:0]         isr,
  output logic [1:0]         ier,
  output logic               irq
);
  logic               wr_ok;
  logic [STAT_W-1:0]  status_q;
  logic [7:0]         rdstat_q;
  logic [WORD_W-1:0]  devid_q;
  logic [PAY_W-1:0]   rddata_q;
  logic               good_read;

  assign wr_ok     = bus_wr && !busy;
  assign wd0_wr    = wr_ok && (bus_addr == OFS_WD0);
  assign good_read = rsp_fire && (rsp_status == '0) && cur_rd;

  always_comb begin
    launch_req  = 1'b0;
    launch_kind = K_RAW;
    launch_hold = 1'b0;
    if (wr_ok) begin
      unique case (bus_addr)
        OFS_OPEN:   begin launch_req = bus_wdata[0]; launch_kind = K_OPEN;  end
        OFS_CLOSE:  begin launch_req = bus_wdata[0]; launch_kind = K_CLOSE; end
        OFS_WREN:   begin launch_req = bus_wdata[0]; launch_kind = K_WREN;  end
        OFS_WRSTAT: begin launch_req = 1'b1; launch_kind = K_WRSTAT; end
        OFS_RDSTAT: begin launch_req = 1'b1; launch_kind = K_RDSTAT; end
        OFS_ERASE:  begin launch_req = 1'b1; launch_kind = K_ERASE;  end
        OFS_DEVID:  begin launch_req = 1'b1; launch_kind = K_DEVID;  end
        OFS_CTRL: begin
          launch_req  = bus_wdata[0];
          launch_kind = K_RAW;
          launch_hold = bus_wdata[5];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier         <= 2'b11;
      isr         <= 2'b00;
      csel        <= '0;
      ctrl_opcode <= '0;
      ctrl_rd     <= 1'b0;
      ctrl_wr     <= 1'b0;
      nbytes_reg  <= '0;
      wdata0      <= '0;
      wdata1      <= '0;
      wrstat_reg  <= '0;
      erase_addr  <= '0;
    end else begin
      if (wr_ok) begin
        unique case (bus_addr)
          OFS_ISR:    if (bus_wdata[1]) isr[1] <= 1'b0;
          OFS_IER:    ier <= bus_wdata[1:0];
          OFS_CSEL:   csel <= bus_wdata[CS_W-1:0];
          OFS_WRSTAT: wrstat_reg <= bus_wdata[7:0];
          OFS_ERASE:  erase_addr <= bus_wdata;
          OFS_CTRL: begin
            ctrl_opcode <= bus_wdata[31:24];
            ctrl_rd     <= bus_wdata[6];
            ctrl_wr     <= bus_wdata[5];
          end
          OFS_NB:     nbytes_reg <= bus_wdata[CNT_W-1:0];
          OFS_WD0:    wdata0 <= bus_wdata;
          OFS_WD1:    wdata1 <= bus_wdata;
          default: ;
        endcase
      end
      if (rsp_fire && rsp_status != '0) isr[0] <= 1'b1;
      if (good_read) isr[1] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      rdstat_q <= '0;
      devid_q  <= '0;
      rddata_q <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= |(isr & ier);
      if (rsp_fire) status_q <= rsp_status;
      if (good_read) begin
        unique case (cur_kind)
          K_RAW:    rddata_q <= rsp_data;
          K_RDSTAT: rdstat_q <= rsp_data[7:0];
          K_DEVID:  devid_q  <= rsp_data[WORD_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_STATUS: bus_rdata = WORD_W'({busy, status_q});
      OFS_ISR:    bus_rdata = WORD_W'(isr);
      OFS_IER:    bus_rdata = WORD_W'(ier);
      OFS_CSEL:   bus_rdata = WORD_W'(csel);
      OFS_RDSTAT: bus_rdata = WORD_W'(rdstat_q);
      OFS_DEVID:  bus_rdata = devid_q;
      OFS_CTRL:   bus_rdata = {ctrl_opcode, 17'd0, ctrl_rd, ctrl_wr, 5'd0};
      OFS_NB:     bus_rdata = WORD_W'(nbytes_reg);
      OFS_RD0:    bus_rdata = rddata_q[WORD_W-1:0];
      OFS_RD1:    bus_rdata = rddata_q[PAY_W-1:WORD_W];
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fmb_cmd_frontend.sv
module fmb_cmd_frontend
  import fmb_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [2:0]         req_kind,
  output logic [OPC_W-1:0]   req_opcode,
  output logic               req_rd,
  output logic               req_wr,
  output logic [CNT_W-1:0]   req_nbytes,
  output logic [PAY_W-1:0]   req_data,
  output logic [CS_W-1:0]    req_cs,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [STAT_W-1:0]  rsp_status,
  input  logic [PAY_W-1:0]   rsp_data,
  output logic               irq
);
  logic              busy, rsp_fire, launch_req, launch_hold, wd0_wr;
  cmd_kind_e         launch_kind, kind_q;
  logic [OPC_W-1:0]  ctrl_opcode;
  logic              ctrl_rd, ctrl_wr;
  logic [CNT_W-1:0]  nbytes_reg;
  logic [WORD_W-1:0] wdata0, wdata1, erase_addr;
  logic [7:0]        wrstat_reg;
  logic [CS_W-1:0]   csel;
  logic [1:0]        isr, ier;
  cmd_pkt_t          pkt;

  fmb_regfile u_regs (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .busy, .rsp_fire, .rsp_status, .rsp_data,
    .cur_kind(kind_q), .cur_rd(pkt.rd),
    .launch_req, .launch_kind, .launch_hold, .wd0_wr,
    .ctrl_opcode, .ctrl_rd, .ctrl_wr, .nbytes_reg, .wdata0, .wdata1,
    .wrstat_reg, .erase_addr, .csel, .isr, .ier, .irq
  );

  fmb_launcher u_launch (
    .clk, .rst_n, .launch_req, .launch_kind, .launch_hold, .wd0_wr,
    .req_ready, .rsp_valid, .kind_q, .req_valid, .rsp_ready, .busy, .rsp_fire
  );

  fmb_packer #(.MAX_BYTES(MAX_BYTES)) u_pack (
    .kind(kind_q), .ctrl_opcode, .ctrl_rd, .ctrl_wr, .nbytes_reg,
    .wdata0, .wdata1, .wrstat_reg, .erase_addr, .csel, .pkt
  );

  assign req_kind   = pkt.kind;
  assign req_opcode = pkt.opcode;
  assign req_rd     = pkt.rd;
  assign req_wr     = pkt.wr;
  assign req_nbytes = pkt.nbytes;
  assign req_data   = pkt.data;
  assign req_cs     = pkt.cs;
endmodule

// File: rtl/fmb_checker.sv
module fmb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_kind,
  input logic [7:0]  req_opcode,
  input logic [3:0]  req_nbytes,
  input logic [63:0] req_data,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [10:0] rsp_status,
  input logic [1:0]  isr,
  input logic [1:0]  ier,
  input logic        irq
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_kind) &&
      $stable(req_opcode) && $stable(req_nbytes) && $stable(req_data));

  assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_nbytes <= 4'd8);

  assert_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  assert_errset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_status != 11'd0 |=> isr[0]);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    isr[0] |=> isr[0]);

  assert_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(isr & ier)));
endmodule

bind fmb_cmd_frontend fmb_checker u_fmb_chk (
  .clk, .rst_n, .req_valid, .req_ready, .req_kind, .req_opcode,
  .req_nbytes, .req_data, .rsp_valid, .rsp_ready, .rsp_status,
  .isr, .ier, .irq
);

// File: tb/tb_fmb_cmd_frontend.sv
module tb_fmb_cmd_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [2:0]  req_kind;
  logic [7:0]  req_opcode;
  logic        req_rd, req_wr;
  logic [3:0]  req_nbytes;
  logic [63:0] req_data;
  logic [3:0]  req_cs;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [10:0] rsp_status = '0;
  logic [63:0] rsp_data = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fmb_cmd_frontend dut (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .req_valid, .req_ready, .req_kind, .req_opcode, .req_rd, .req_wr,
    .req_nbytes, .req_data, .req_cs, .rsp_valid, .rsp_ready,
    .rsp_status, .rsp_data, .irq
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, {32'd0, v}, {32'd0, exp});
  endtask

  // Serves one packet: checks fields, applies back-pressure, answers.
  task automatic serve(input string tag, input logic [2:0] kind, input logic [7:0] opc,
                       input logic rdf, input logic wrf, input logic [3:0] nb,
                       input logic [63:0] data, input logic [3:0] cs, input int delay,
                       input logic [10:0] st, input logic [63:0] rdat, input bit poke);
    int waited = 0;
    while (!req_valid && waited < 20) begin @(negedge clk); waited++; end
    chk({tag, " R7 packet present"}, {63'd0, req_valid}, 64'd1);
    chk({tag, " kind"}, {61'd0, req_kind}, {61'd0, kind});
    chk({tag, " opcode"}, {56'd0, req_opcode}, {56'd0, opc});
    chk({tag, " flags"}, {62'd0, req_rd, req_wr}, {62'd0, rdf, wrf});
    chk({tag, " nbytes"}, {60'd0, req_nbytes}, {60'd0, nb});
    chk({tag, " data"}, req_data, data);
    chk({tag, " cs"}, {60'd0, req_cs}, {60'd0, cs});
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk({tag, " R7 held"}, {63'd0, req_valid}, 64'd1);
      chk({tag, " R7 data stable"}, req_data, data);
    end
    rdchk({tag, " R8 busy bit"}, 5'd0, 32'h800 | 32'(dut.u_regs.status_q));
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk({tag, " R7 valid drops"}, {63'd0, req_valid}, 64'd0);
    chk({tag, " R8 rsp_ready"}, {63'd0, rsp_ready}, 64'd1);
    if (poke) begin
      wr(5'd3, 32'h9);
      wr(5'd2, 32'h0);
      wr(5'd13, 32'h77000001);
      wr(5'd11, 32'h1);
      chk({tag, " R9 no extra packet"}, {63'd0, req_valid}, 64'd0);
    end
    rsp_valid = 1'b1; rsp_status = st; rsp_data = rdat;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk({tag, " R8 rsp_ready low"}, {63'd0, rsp_ready}, 64'd0);
    rdchk({tag, " R8 status"}, 5'd0, {21'd0, st});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ea;
    logic [63:0] sw;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R13 reset state over every offset
    for (int a = 0; a < 27; a++) begin
      rdchk($sformatf("R1 reset offset %0d", a), 5'(a), (a == 2) ? 32'd3 : 32'd0);
    end
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 req_valid", {63'd0, req_valid}, 64'd0);

    wr(5'd3, 32'h5);
    rdchk("R2 cs readback", 5'd3, 32'h5);

    // R2, R4: sweep of all byte counts
    for (int n = 0; n < 16; n++) begin
      logic [7:0] op;
      op = 8'(n * 17 + 3);
      wr(5'd14, 32'(n));
      wr(5'd16, 32'hA000_0000 + 32'(n));
      wr(5'd15, 32'h0B00_0000 + 32'(n));
      wr(5'd13, {op, 24'h000001});
      serve($sformatf("R2 R4 raw n=%0d", n), 3'd0, op, 1'b0, 1'b0,
            (n > 8) ? 4'd8 : 4'(n),
            {32'hA000_0000 + 32'(n), 32'h0B00_0000 + 32'(n)}, 4'h5, n % 3,
            11'd0, 64'd0, 1'b0);
    end

    // R3: deferred launch until WRITEDATA_0
    wr(5'd13, 32'h9F000021);
    repeat (3) @(negedge clk);
    chk("R3 armed no packet", {63'd0, req_valid}, 64'd0);
    rdchk("R3 not busy while armed", 5'd0, 32'd0);
    wr(5'd14, 32'd6);
    wr(5'd16, 32'h1234_5678);
    chk("R3 still waiting", {63'd0, req_valid}, 64'd0);
    wr(5'd15, 32'h9ABC_DEF0);
    serve("R3 deferred", 3'd0, 8'h9F, 1'b0, 1'b1, 4'd6, 64'h1234_5678_9ABC_DEF0,
          4'h5, 1, 11'd0, 64'd0, 1'b0);

    // R5 fixed functions
    wr(5'd4, 32'h0);
    wr(5'd5, 32'h2);
    repeat (2) @(negedge clk);
    chk("R5 zero bit0 sends nothing", {63'd0, req_valid}, 64'd0);
    wr(5'd4, 32'h1);
    serve("R5 open", 3'd1, 8'd0, 1'b0, 1'b0, 4'd0, 64'd0, 4'h5, 0, 11'd0, 64'd0, 1'b0);
    wr(5'd5, 32'h1);
    serve("R5 close", 3'd2, 8'd0, 1'b0, 1'b0, 4'd0, 64'd0, 4'h5, 2, 11'd0, 64'd0, 1'b0);
    wr(5'd6, 32'h1);
    serve("R5 wren", 3'd3, 8'd0, 1'b0, 1'b0, 4'd0, 64'd0, 4'h5, 0, 11'd0, 64'd0, 1'b0);
    wr(5'd7, 32'hFFFF_FFA5);
    serve("R5 wrstat", 3'd4, 8'd0, 1'b0, 1'b1, 4'd1, 64'h0A5, 4'h5, 1, 11'd0, 64'd0, 1'b0);

    // R6 erase byte order sweep
    for (int k = 0; k < 6; k++) begin
      ea = 32'h04FF_0000 ^ (32'h1357_9BDF * 32'(k));
      sw = {32'd0, ea[7:0], ea[15:8], ea[23:16], ea[31:24]};
      wr(5'd9, ea);
      serve($sformatf("R6 erase k=%0d", k), 3'd6, 8'd0, 1'b0, 1'b1, 4'd4, sw, 4'h5,
            k % 2, 11'd0, 64'd0, 1'b0);
    end

    // R9 writes during busy ignored
    wr(5'd13, 32'h0B000001);
    serve("R9 busy", 3'd0, 8'h0B, 1'b0, 1'b0, 4'd6, 64'h1234_5678_9ABC_DEF0,
          4'h5, 0, 11'd0, 64'd0, 1'b1);
    rdchk("R9 cs unchanged", 5'd3, 32'h5);
    rdchk("R9 ier unchanged", 5'd2, 32'h3);
    rdchk("R9 control unchanged", 5'd13, 32'h0B000000);
    @(negedge clk);
    chk("R9 no second packet", {63'd0, req_valid}, 64'd0);

    // R11 raw read data
    wr(5'd14, 32'd8);
    wr(5'd13, 32'h0B000041);
    serve("R11 raw read", 3'd0, 8'h0B, 1'b1, 1'b0, 4'd8, 64'h1234_5678_9ABC_DEF0,
          4'h5, 0, 11'd0, 64'h1122_3344_5566_7788, 1'b0);
    rdchk("R11 readdata low", 5'd17, 32'h5566_7788);
    rdchk("R11 readdata high", 5'd18, 32'h1122_3344);
    rdchk("R11 isr rd bit", 5'd1, 32'h2);
    @(negedge clk);
    chk("R12 irq from rd bit", {63'd0, irq}, 64'd1);
    wr(5'd1, 32'h2);
    rdchk("R11 rd bit cleared", 5'd1, 32'h0);
    @(negedge clk);
    chk("R12 irq clears", {63'd0, irq}, 64'd0);

    wr(5'd8, 32'h0);
    serve("R11 rdstat", 3'd5, 8'd0, 1'b1, 1'b0, 4'd1, 64'd0, 4'h5, 1, 11'd0,
          64'hFFFF_FFFF_FFFF_FFC3, 1'b0);
    rdchk("R11 rdstat value", 5'd8, 32'hC3);
    wr(5'd10, 32'h0);
    serve("R11 devid", 3'd7, 8'd0, 1'b1, 1'b0, 4'd4, 64'd0, 4'h5, 0, 11'd0,
          64'hDEAD_BEEF_20BA_1A19, 1'b0);
    rdchk("R11 devid value", 5'd10, 32'h20BA_1A19);
    rdchk("R11 readdata untouched", 5'd17, 32'h5566_7788);

    // R12 mask
    wr(5'd2, 32'h1);
    @(negedge clk);
    chk("R12 masked rd bit", {63'd0, irq}, 64'd0);
    wr(5'd2, 32'h2);
    @(negedge clk);
    chk("R12 enabled rd bit", {63'd0, irq}, 64'd1);
    wr(5'd1, 32'h2);
    @(negedge clk);
    chk("R12 cleared", {63'd0, irq}, 64'd0);

    // R13 reserved
    wr(5'd11, 32'hFFFF_FFFF);
    wr(5'd12, 32'hFFFF_FFFF);
    wr(5'd19, 32'hFFFF_FFFF);
    rdchk("R13 off11", 5'd11, 32'd0);
    rdchk("R13 off12", 5'd12, 32'd0);
    rdchk("R13 off19", 5'd19, 32'd0);
    chk("R13 no packet", {63'd0, req_valid}, 64'd0);

    // R10 sticky error; read with error does not set rd bit
    wr(5'd2, 32'h3);
    wr(5'd13, 32'h0B000041);
    serve("R10 error", 3'd0, 8'h0B, 1'b1, 1'b0, 4'd8, 64'h1234_5678_9ABC_DEF0,
          4'h5, 1, 11'h2A5, 64'hFFFF, 1'b0);
    rdchk("R10 isr err only", 5'd1, 32'h1);
    rdchk("R11 readdata kept on error", 5'd17, 32'h5566_7788);
    @(negedge clk);
    chk("R12 irq from err", {63'd0, irq}, 64'd1);
    wr(5'd1, 32'h3);
    rdchk("R10 sticky after write", 5'd1, 32'h1);
    wr(5'd4, 32'h1);
    serve("R10 next ok", 3'd1, 8'd0, 1'b0, 1'b0, 4'd0, 64'd0, 4'h5, 0, 11'd0, 64'd0, 1'b0);
    rdchk("R10 sticky after ok", 5'd1, 32'h1);
    wr(5'd2, 32'h2);
    @(negedge clk);
    chk("R12 err masked", {63'd0, irq}, 64'd0);
    rd(5'd0, v);
    chk("R8 status idle", {32'd0, v}, 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule